// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block is an MDIO management master reached over a simple 32-bit register bus. Software uses it to read and write the 16-bit management registers of an Ethernet PHY. The bus has four word registers: one for the frame address, one for outgoing data, one for captured data and one for control. Software sets the control register's status bit to start a transaction. The block then sends a clause-22 management frame on MDC and the MDIO data line. When the frame is over, the block clears the status bit itself. The same bit therefore acts as the start command and as the busy flag that software polls.

The MDC clock comes from the system clock through a divider. The parameter `MDC_HALF` sets the number of system clocks in each half period. The default of 20 gives 2.5 MHz from a 100 MHz clock. The data line changes only in the system cycle in which MDC rises. On read frames the master releases the line at the turnaround and samples the PHY's data on each rising MDC edge. A master enable bit gates the whole interface. While it is clear, MDC stays low, the line is released and start requests are ignored. Clearing it during a frame abandons the frame.

The frame sequencer has six named states:
- IDLE: no frame is running.
- PREAMBLE: sends 32 ones.
- HEADER: sends the start code, the opcode, the PHY address and the register number.
- TURN: the two turnaround bits.
- DATA: 16 data bits.
- TAIL: waits for the last falling edge of MDC.

The transitions are:
- IDLE→PREAMBLE on an accepted start.
- PREAMBLE→HEADER on the 32nd rising edge.
- HEADER→TURN on the 46th rising edge.
- TURN→DATA on the 48th rising edge.
- DATA→TAIL on the 64th rising edge.
- TAIL→IDLE on the next falling edge.
- Any busy state→IDLE when enable drops.

Top module: `mgmt_mdio_master`

## Requirements
- R1: After reset, every register reads 0, MDC is low and the data-line output enable is 0.
- R2: Register offsets (byte addresses, word aligned) are 0x7E4 for frame address, 0x7E8 for write data, 0x7EC for read data and 0x7F0 for control. In the frame-address register, bits [4:0] are the PHY register number, bits [9:5] are the PHY address and bit 10 is the direction (1 = read, 0 = write). Write data reads back from bits [15:0]. Unused bits, and any other offset, read as 0.
- R3: Writing the control register with bit 0 (status) and bit 3 (enable) both set, while idle, makes status read 1 from the next cycle.
- R4: A frame shifts out, MSB first, 32 ones, then 01, then the opcode (10 for a read, 01 for a write), then the PHY address, then the register number, then turnaround 10 and the 16 write-data bits on writes. The data line holds each bit steady and changes only in the cycle in which MDC rises.
- R5: MDC toggles every `MDC_HALF` system clocks during a frame, gives exactly 64 rising edges per frame, and is low whenever no frame is running.
- R6: On read frames the output enable is 0 for the two turnaround bits and the 16 data bits. The line is sampled at the 16 data rising edges, and the read-data register (bits [15:0]) holds the result once status is 0.
- R7: Status stays 1 for exactly 128·`MDC_HALF` cycles after the start edge, then returns to 0.
- R8: With enable 0, a start request is ignored: status stays 0 and MDC stays low.
- R9: Writing 0 to the status bit during a frame does not clear it. A second start during a frame leaves the frame's bits and length unchanged.
- R10: Clearing enable during a frame makes status 0, MDC low and the output enable 0 from the next cycle, and leaves read data unchanged.
- R11: The read-data register keeps its value through write frames and between frames.
- R12: Control bit 3 reads back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable (0 = released) |
| mdio_i | input | 1 | Data line value seen at the pin |

## Verification
- **Status:** the start write lands on one rising clock edge, and status reads 1 at the next falling edge. The bench counts the falling edges at which status is still 1 and expects exactly 128·`MDC_HALF` of them.
- **Frame bits:** each bit is captured from the value the data line held one sample before MDC was seen high. This is the value the PHY latches, because the design moves to the next bit in the same edge that raises MDC.
- **Read data:** the bench's PHY model presents read data at falling system-clock edges, ahead of each rising MDC edge. The read-data register is compared only after status has cleared.
- **Abort:** the effect of clearing enable is checked at the first falling edge after the write lands.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int REG_ADDR_W = 12;
    localparam int BUS_W      = 32;
    localparam int MII_DATA_W = 16;
    localparam int MII_ADR_W  = 5;

    localparam logic [REG_ADDR_W-1:0] OFS_FRAME_ADR = 12'h7E4;
    localparam logic [REG_ADDR_W-1:0] OFS_WR_DATA   = 12'h7E8;
    localparam logic [REG_ADDR_W-1:0] OFS_RD_DATA   = 12'h7EC;
    localparam logic [REG_ADDR_W-1:0] OFS_CONTROL   = 12'h7F0;

    localparam int CTL_STATUS_BIT = 0;
    localparam int CTL_ENABLE_BIT = 3;
    localparam int ADR_DIR_BIT    = 2 * MII_ADR_W;
    localparam int ADR_FIELD_W    = ADR_DIR_BIT + 1;

    localparam int PRE_LEN   = 32;
    localparam int HDR_LEN   = 4 + 2 * MII_ADR_W;
    localparam int TA_LEN    = 2;
    localparam int FRAME_LEN = PRE_LEN + HDR_LEN + TA_LEN + MII_DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    localparam int LAST_PRE  = PRE_LEN - 1;
    localparam int LAST_HDR  = PRE_LEN + HDR_LEN - 1;
    localparam int LAST_TA   = PRE_LEN + HDR_LEN + TA_LEN - 1;
    localparam int LAST_DATA = FRAME_LEN - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_TAIL
    } frame_state_t;

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          half_tick;

    assign half_tick = run && (cnt_q == CNT_LAST);
    assign rise_tick = half_tick && !mdc_q;
    assign fall_tick = half_tick && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (half_tick) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   start,
    input  logic                   op_read,
    input  logic [MII_ADR_W-1:0]   phy_adr,
    input  logic [MII_ADR_W-1:0]   reg_adr,
    input  logic [MII_DATA_W-1:0]  wr_word,
    input  logic                   rise_tick,
    input  logic                   fall_tick,
    input  logic                   mdio_in,
    output logic                   busy,
    output logic                   done,
    output logic                   done_read,
    output logic [MII_DATA_W-1:0]  rd_word,
    output logic                   mdio_out,
    output logic                   mdio_oe
);
    frame_state_t            state_q, state_d;
    logic [FRAME_LEN-1:0]    shift_q;
    logic [IDX_W-1:0]        idx_q;
    logic                    rd_op_q;
    logic [MII_DATA_W-1:0]   cap_q;
    logic                    shifting;

    assign shifting = rise_tick && (state_q inside {ST_PREAMBLE, ST_HEADER, ST_TURN, ST_DATA});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (rise_tick && idx_q == IDX_W'(LAST_PRE))  state_d = ST_HEADER;
            ST_HEADER:   if (rise_tick && idx_q == IDX_W'(LAST_HDR))  state_d = ST_TURN;
            ST_TURN:     if (rise_tick && idx_q == IDX_W'(LAST_TA))   state_d = ST_DATA;
            ST_DATA:     if (rise_tick && idx_q == IDX_W'(LAST_DATA)) state_d = ST_TAIL;
            ST_TAIL:     if (fall_tick) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (state_q != ST_IDLE && !enable) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shift_q <= '0;
            idx_q   <= '0;
            rd_op_q <= 1'b0;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                shift_q <= {{PRE_LEN{1'b1}}, 2'b01,
                            (op_read ? 2'b10 : 2'b01),
                            phy_adr, reg_adr, 2'b10, wr_word};
                idx_q   <= '0;
                rd_op_q <= op_read;
            end else if (shifting) begin
                shift_q <= {shift_q[FRAME_LEN-2:0], 1'b0};
                idx_q   <= idx_q + 1'b1;
                if (state_q == ST_DATA) cap_q <= {cap_q[MII_DATA_W-2:0], mdio_in};
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_TAIL) && fall_tick && enable;
        done_read = rd_op_q;
        rd_word   = cap_q;
        mdio_out  = shift_q[FRAME_LEN-1];
        unique case (state_q)
            ST_PREAMBLE, ST_HEADER: mdio_oe = 1'b1;
            ST_TURN, ST_DATA:       mdio_oe = !rd_op_q;
            default:                mdio_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_mgmt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [REG_ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    input  logic                   busy,
    input  logic                   done,
    input  logic                   done_read,
    input  logic [MII_DATA_W-1:0]  rd_word,
    output logic                   en_q,
    output logic                   en_next,
    output logic                   start,
    output logic                   op_read,
    output logic [MII_ADR_W-1:0]   phy_adr,
    output logic [MII_ADR_W-1:0]   reg_adr,
    output logic [MII_DATA_W-1:0]  wr_word,
    output logic [MII_DATA_W-1:0]  rd_hold
);
    logic [ADR_FIELD_W-1:0] adr_q;
    logic [MII_DATA_W-1:0]  wdat_q;
    logic [MII_DATA_W-1:0]  rdat_q;
    logic                   ctl_wr;
    logic                   unused_hi;

    assign unused_hi = ^bus_wdata[BUS_W-1:MII_DATA_W];
    assign ctl_wr    = bus_wr && (bus_addr == OFS_CONTROL);
    assign en_next   = ctl_wr ? bus_wdata[CTL_ENABLE_BIT] : en_q;
    assign start     = ctl_wr && bus_wdata[CTL_STATUS_BIT] && bus_wdata[CTL_ENABLE_BIT] && !busy;
    assign op_read   = adr_q[ADR_DIR_BIT];
    assign phy_adr   = adr_q[2*MII_ADR_W-1:MII_ADR_W];
    assign reg_adr   = adr_q[MII_ADR_W-1:0];
    assign wr_word   = wdat_q;
    assign rd_hold   = rdat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q  <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == OFS_FRAME_ADR) adr_q  <= bus_wdata[ADR_FIELD_W-1:0];
            if (bus_wr && bus_addr == OFS_WR_DATA)   wdat_q <= bus_wdata[MII_DATA_W-1:0];
            en_q <= en_next;
            if (done && done_read) rdat_q <= rd_word;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_FRAME_ADR: bus_rdata[ADR_FIELD_W-1:0] = adr_q;
            OFS_WR_DATA:   bus_rdata[MII_DATA_W-1:0]  = wdat_q;
            OFS_RD_DATA:   bus_rdata[MII_DATA_W-1:0]  = rdat_q;
            OFS_CONTROL: begin
                bus_rdata[CTL_ENABLE_BIT] = en_q;
                bus_rdata[CTL_STATUS_BIT] = busy;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mgmt_mdio_master.sv
module mgmt_mdio_master
    import mdio_mgmt_pkg::*;
#(
    parameter int MDC_HALF = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic                  en_q, en_next, start_req, op_read;
    logic [MII_ADR_W-1:0]  phy_adr, reg_adr;
    logic [MII_DATA_W-1:0] wr_word, rd_word, rd_hold;
    logic                  seq_busy, seq_done, seq_done_read;
    logic                  rise_tick, fall_tick;

    mdio_reg_bank u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(seq_busy), .done(seq_done), .done_read(seq_done_read), .rd_word(rd_word),
        .en_q(en_q), .en_next(en_next), .start(start_req), .op_read(op_read),
        .phy_adr(phy_adr), .reg_adr(reg_adr), .wr_word(wr_word), .rd_hold(rd_hold)
    );

    mdio_clk_gen #(.HALF_DIV(MDC_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(seq_busy && en_next),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_seq u_seq (
        .clk(clk), .rst_n(rst_n), .enable(en_next), .start(start_req),
        .op_read(op_read), .phy_adr(phy_adr), .reg_adr(reg_adr), .wr_word(wr_word),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_in(mdio_i),
        .busy(seq_busy), .done(seq_done), .done_read(seq_done_read), .rd_word(rd_word),
        .mdio_out(mdio_o), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mgmt_mdio_master_chk.sv
module mgmt_mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        en,
    input logic        busy,
    input logic        done,
    input logic        start,
    input logic [15:0] rd_hold
);
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!mdc && !mdio_oe && !busy));

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    p_bit_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !(mdc && !$past(mdc))) |-> $stable(mdio_o));

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rd_hold));

    p_hw_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(done) || !en));
endmodule

bind mgmt_mdio_master mgmt_mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .en(en_q), .busy(seq_busy), .done(seq_done), .start(start_req), .rd_hold(rd_hold)
);

// File: tb/mgmt_mdio_master_test.sv
module mgmt_mdio_master_test;
    localparam int HALF = 3;
    localparam logic [11:0] A_ADR = 12'h7E4, A_WD = 12'h7E8, A_RD = 12'h7EC, A_CTL = 12'h7F0;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, mdio_i = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        mdc, mdio_o, mdio_oe;

    mgmt_mdio_master #(.MDC_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #5 clk = !clk;

    int n_chk = 0, n_bad = 0, cyc = 0, rises = 0, glitches = 0, base = 0;
    bit finished = 1'b0;
    logic [63:0] cap_bits = '0, cap_oe = '0;
    logic [15:0] phy_val = '0;
    logic mdc_prev = 1'b0, dat_prev = 1'b0, oe_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        int k;
        if (mdc && !mdc_prev) begin
            rises    = rises + 1;
            cap_bits = {cap_bits[62:0], dat_prev};
            cap_oe   = {cap_oe[62:0], oe_prev};
        end
        if (mdio_oe && oe_prev && (mdio_o != dat_prev) && !(mdc && !mdc_prev)) glitches = glitches + 1;
        mdc_prev = mdc; dat_prev = mdio_o; oe_prev = mdio_oe;
        k = rises - base;
        mdio_i = (k >= 48 && k <= 63) ? phy_val[63-k] : 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] data, input logic [15:0] pval, input bit poke);
        logic [31:0] v, old_rd;
        logic [63:0] exp, mask;
        int t0, g0;
        phy_val = pval; base = rises; g0 = glitches;
        bus_read(A_RD, old_rd);
        bus_write(A_ADR, {21'd0, rd, phy, rg});
        bus_write(A_WD, {16'd0, data});
        bus_write(A_CTL, 32'h9);
        t0 = cyc;
        bus_read(A_CTL, v);
        check("R3 status after start", 64'(v[0]), 64'd1);
        if (poke) begin
            repeat (20) @(negedge clk);
            bus_write(A_CTL, 32'h8);
            bus_read(A_CTL, v);
            check("R9 status after writing 0", 64'(v[0]), 64'd1);
            bus_write(A_ADR, {21'd0, !rd, ~phy, ~rg});
            bus_write(A_CTL, 32'h9);
        end
        forever begin
            bus_read(A_CTL, v);
            if (v[0] == 1'b0) break;
            @(negedge clk);
        end
        check("R7 busy length", 64'(cyc - t0), 64'(128 * HALF));
        check("R5 rising edges per frame", 64'(rises - base), 64'd64);
        check("R5 mdc low when idle", {63'd0, mdc}, 64'd0);
        exp  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, data};
        mask = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
        check("R4 frame bits", cap_bits & mask, exp & mask);
        check(rd ? "R6 released in turnaround and data" : "R4 driven throughout", cap_oe, mask);
        check("R4 line changes only at rising mdc", 64'(glitches - g0), 64'd0);
        bus_read(A_RD, v);
        if (rd) check("R6 read data captured", 64'(v), 64'(pval));
        else    check("R11 read data kept over write", 64'(v), 64'(old_rd));
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(A_ADR, v); check("R1 reset address reg", 64'(v), 0);
        bus_read(A_WD, v);  check("R1 reset write data", 64'(v), 0);
        bus_read(A_RD, v);  check("R1 reset read data", 64'(v), 0);
        bus_read(A_CTL, v); check("R1 reset control", 64'(v), 0);
        check("R1 reset mdc/oe", {62'd0, mdc, mdio_oe}, 0);

        bus_write(A_ADR, 32'hFFFF_FFFF);
        bus_read(A_ADR, v); check("R2 address field width", 64'(v), 64'h7FF);
        bus_write(A_WD, 32'hFFFF_FFFF);
        bus_read(A_WD, v); check("R2 write data width", 64'(v), 64'hFFFF);
        bus_read(12'h7F4, v); check("R2 unmapped offset", 64'(v), 0);
        bus_write(A_ADR, 32'h0);

        bus_write(A_CTL, 32'h1);
        bus_read(A_CTL, v); check("R8 start ignored while disabled", 64'(v), 0);
        repeat (4 * HALF) @(negedge clk);
        check("R8 mdc stays low", {63'd0, mdc}, 0);

        bus_write(A_CTL, 32'h8);
        bus_read(A_CTL, v); check("R12 enable readback", 64'(v), 64'h8);

        run_frame(1'b1, 5'd0,  5'd0,  16'h0000, 16'hFFFF, 1'b0);
        run_frame(1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 1'b0);
        run_frame(1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000, 1'b0);
        run_frame(1'b1, 5'd31, 5'd31, 16'h0000, 16'h0001, 1'b0);
        for (int i = 0; i < 16; i++)
            run_frame(i[0], 5'(2 * i + 1), 5'(31 - i), 16'hA5C3 ^ 16'(i * 16'h1111),
                      16'h3C96 + 16'(i * 16'h0F0F), 1'b0);
        run_frame(1'b0, 5'd9, 5'd22, 16'h8001, 16'h0000, 1'b1);
        run_frame(1'b1, 5'd17, 5'd4, 16'h0000, 16'hBEEF, 1'b1);

        bus_read(A_RD, v);
        bus_write(A_ADR, 32'h400 | (5 << 5) | 3);
        bus_write(A_CTL, 32'h9);
        repeat (40) @(negedge clk);
        bus_write(A_CTL, 32'h0);
        begin
            logic [31:0] c, r;
            bus_read(A_CTL, c); check("R10 abort clears status", 64'(c), 0);
            check("R10 abort quiets mdc/oe", {62'd0, mdc, mdio_oe}, 0);
            bus_read(A_RD, r); check("R10 read data unchanged by abort", 64'(r), 64'(v));
        end
        bus_write(A_CTL, 32'h8);
        run_frame(1'b1, 5'd3, 5'd12, 16'h0000, 16'h1234, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule